// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines for a small processor and drives one interrupt output toward it. Each request line passes through a synchronizer into a line-state vector. A pending register ORs in that vector every cycle, so a request that has been seen stays recorded after its line drops. A mask register chooses which pending bits may raise the processor interrupt.

Software uses a plain synchronous register port with a select, a write enable, an offset and write data. Through this port it reads the mask, the pending bits and the live line state, and it writes the mask. Writing ones to the pending offset acknowledges interrupts. A line that is still held high is marked pending again at once, so an acknowledge cannot lose a live request.

For debug, every line has an occurrence counter that counts the rising edges of the synchronized line. Software reads these counters at offsets 32 and up.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: Each request line reaches the line-state vector through a two-flop synchronizer. A read of offset 2 returns the line state in bit i for line i, zero-extended to the data width.
- R2: Every cycle the pending register takes its previous value ORed with the line-state vector. A pending bit stays set after its line drops. A read of offset 1 returns the pending bits.
- R3: irqOut is high exactly when the bitwise AND of pending and mask has at least one bit set.
- R4: A write to offset 1 clears each pending bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A line whose synchronized state is high during an acknowledge write stays pending. When an acknowledge and an assertion meet on the same bit, the assertion wins.
- R6: A write to offset 0 replaces the mask with write-data bits [NUM_LINES-1:0]. irqOut reflects the new mask from the clock edge that performs the write, and offset 0 reads the mask back.
- R7: Reset (rstN low) clears the mask, the pending bits, the synchronizer and line state, and every occurrence counter, so irqOut is low.
- R8: The counter of line i increments by one on each rising edge of that line's synchronized state. A line that stays high counts once. Offset 32+i reads the counter, zero-extended.
- R9: A counter wraps to zero after its all-ones value, modulo 2^CNT_W; it does not saturate.
- R10: Read data appears on rdData one clock after a cycle with sel=1 and wrEn=0, and is zero otherwise. Offsets not listed above read as zero, and writes to the read-only offsets (2 and 32..63) change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_LINES | Level-sensitive request lines, asynchronous |
| sel | input | 1 | Register port select |
| wrEn | input | 1 | Write enable, qualified by sel |
| addr | input | ADDR_W | Register offset |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with 32 lines, a 32-bit data port and the two-flop synchronizer, but with CNT_W set to 4. At full width the counter wrap of R9 is out of reach in a short run; with 4-bit counters it follows after 17 pulses on one line. This narrower width also tests the zero-extension of counter reads and the indexed counter readback. The other parameters stay at their defaults, so the full 32-line mask, pending and acknowledge behaviour is covered with the real offset map.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_MASK,
    SRC_PEND,
    SRC_LINE,
    SRC_CNT
  } rdSrc_e;

  typedef struct packed {
    logic   maskWr;
    logic   ackWr;
    logic   rdEn;
    rdSrc_e rdSrc;
  } ctrlStrb_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 6,
  parameter int CNT_BASE  = 32,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb,
  output logic [IDX_W-1:0]  cntIdx
);

  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_LINE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] CNT_LO   = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HI   = ADDR_W'(CNT_BASE + NUM_LINES - 1);

  logic isCnt;
  logic [ADDR_W-1:0] cntOfs;

  assign isCnt  = (addr >= CNT_LO) && (addr <= CNT_HI);
  assign cntOfs = addr - CNT_LO;
  assign cntIdx = cntOfs[IDX_W-1:0];

  always_comb begin
    strb.maskWr = sel && wrEn && (addr == OFS_MASK);
    strb.ackWr  = sel && wrEn && (addr == OFS_PEND);
    strb.rdEn   = sel && !wrEn;
    if (isCnt)                 strb.rdSrc = SRC_CNT;
    else if (addr == OFS_MASK) strb.rdSrc = SRC_MASK;
    else if (addr == OFS_PEND) strb.rdSrc = SRC_PEND;
    else if (addr == OFS_LINE) strb.rdSrc = SRC_LINE;
    else                       strb.rdSrc = SRC_NONE;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  ctrlStrb_t            strb,
  input  logic [IDX_W-1:0]     cntIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] lineState,
  output logic [NUM_LINES-1:0] pendingQ,
  output logic [NUM_LINES-1:0] maskQ
);

  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] linePrev;
  logic [NUM_LINES-1:0] riseVec;
  logic [NUM_LINES-1:0] ackVec;
  logic [NUM_LINES*CNT_W-1:0] cntFlat;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign lineState = syncQ[SYNC_STAGES-1];
  assign riseVec   = lineState & ~linePrev;
  assign ackVec    = strb.ackWr ? wrData[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linePrev <= '0;
      pendingQ <= '0;
      maskQ    <= '0;
    end else begin
      linePrev <= lineState;
      pendingQ <= (pendingQ & ~ackVec) | lineState;
      if (strb.maskWr) maskQ <= wrData[NUM_LINES-1:0];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cnt <= '0;
      else if (riseVec[g]) cnt <= cnt + CNT_W'(1);
    end
    assign cntFlat[g*CNT_W +: CNT_W] = cnt;
  end

  always_comb begin
    unique case (strb.rdSrc)
      SRC_MASK: rdNext = DATA_W'(maskQ);
      SRC_PEND: rdNext = DATA_W'(pendingQ);
      SRC_LINE: rdNext = DATA_W'(lineState);
      SRC_CNT:  rdNext = DATA_W'(cntFlat[cntIdx*CNT_W +: CNT_W]);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
    else                rdData <= '0;
  end

endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int CNT_BASE    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 sel,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);

  ctrlStrb_t            strb;
  logic [IDX_W-1:0]     cntIdx;
  logic [NUM_LINES-1:0] lineState;
  logic [NUM_LINES-1:0] pendingQ;
  logic [NUM_LINES-1:0] maskQ;

  irqc_ctrl #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE)
  ) uCtrl (
    .sel(sel), .wrEn(wrEn), .addr(addr), .strb(strb), .cntIdx(cntIdx)
  );

  irqc_datapath #(
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strb(strb), .cntIdx(cntIdx),
    .wrData(wrData), .rdData(rdData), .lineState(lineState),
    .pendingQ(pendingQ), .maskQ(maskQ)
  );

  assign irqOut = |(pendingQ & maskQ);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LINES   = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 sel,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] lineState,
  input logic [NUM_LINES-1:0] pendingQ,
  input logic [NUM_LINES-1:0] maskQ
);

  logic [1:0] cyc;
  logic ackWrite, maskWrite;

  assign ackWrite  = sel && wrEn && (addr == ADDR_W'(1));
  assign maskWrite = sel && wrEn && (addr == ADDR_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : gSyncChk
    assert_line_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
      (cyc >= 2'd2) |-> (lineState == $past(irqIn, 2)));
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ackWrite |=> (($past(pendingQ) & ~pendingQ) == '0));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);

  assert_irq_has_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (pendingQ != '0));

  assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackWrite |=> ((pendingQ & $past(wrData[NUM_LINES-1:0] & ~lineState)) == '0));

  assert_held_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(lineState) & ~pendingQ) == '0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    maskWrite |=> (maskQ == $past(wrData[NUM_LINES-1:0])));

endmodule

bind irq_sticky_ctrl irqc_checker #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SYNC_STAGES(SYNC_STAGES)
) uChk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .sel(sel), .wrEn(wrEn),
  .addr(addr), .wrData(wrData), .irqOut(irqOut), .lineState(lineState),
  .pendingQ(pendingQ), .maskQ(maskQ)
);

// File: tb/irq_sticky_ctrl_test.sv
`timescale 1ns/1ps
module irq_sticky_ctrl_test;

  localparam int NL = 32;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] irqIn = '0;
  logic sel = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_sticky_ctrl #(.NUM_LINES(NL), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .sel(sel), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // pattern, mask, ack
  localparam logic [95:0] VEC [6] = '{
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    {32'h8000_0010, 32'h0000_0010, 32'h0000_0010},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0F0F},
    {32'hA5A5_0000, 32'h0000_FFFF, 32'h0000_0000},
    {32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678},
    {32'h00F0_000F, 32'h0000_0008, 32'h0000_0003}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    sel = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; wrEn = 1'b0; addr = a;
    @(negedge clk);
    d = rdData;
    sel = 1'b0;
  endtask

  task automatic pulse(input int line, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); irqIn[line] = 1'b1;
      waitCyc(3);
      irqIn[line] = 1'b0;
      waitCyc(3);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] d;
    logic [NL-1:0] pat, msk, ack, expP;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R7 reset state
    check("R7 irqOut after reset", DW'(irqOut), '0);
    doRead(0, d); check("R7 mask after reset", d, '0);
    doRead(1, d); check("R7 pending after reset", d, '0);
    doRead(2, d); check("R7 line after reset", d, '0);
    doRead(6'd32, d); check("R7 counter0 after reset", d, '0);
    doRead(6'd63, d); check("R7 counter31 after reset", d, '0);

    // table-driven patterns: R2, R4, R3
    for (int i = 0; i < 6; i++) begin
      pat = VEC[i][95:64]; msk = VEC[i][63:32]; ack = VEC[i][31:0];
      irqIn = '0;
      waitCyc(4);
      doWrite(1, '1);
      doWrite(0, DW'(msk));
      @(negedge clk); irqIn = pat;
      waitCyc(4);
      irqIn = '0;
      waitCyc(4);
      doRead(1, d); check($sformatf("R2 sticky pending vec%0d", i), d, DW'(pat));
      expP = pat & ~ack;
      doWrite(1, DW'(ack));
      doRead(1, d); check($sformatf("R4 pending after ack vec%0d", i), d, DW'(expP));
      check($sformatf("R3 irqOut vec%0d", i), DW'(irqOut), DW'(|(expP & msk)));
    end

    // R1 line state readback and synchronizer latency
    doWrite(1, '1);
    doWrite(0, '0);
    @(negedge clk); irqIn = 32'h0000_C003;
    @(negedge clk); // one edge: only first flop loaded
    sel = 1'b1; addr = 2;
    @(negedge clk); d = rdData; sel = 1'b0;
    check("R1 line state not yet visible after one edge", d, '0);
    waitCyc(2);
    doRead(2, d); check("R1 line state after sync", d, 32'h0000_C003);

    // R5 held line survives acknowledge
    doWrite(1, 32'h0000_C003);
    doRead(1, d); check("R5 held lines stay pending", d, 32'h0000_C003);
    irqIn = '0;
    waitCyc(4);
    doWrite(1, 32'h0000_0003);
    doRead(1, d); check("R4 partial ack leaves zero-written bits", d, 32'h0000_C000);

    // R6 mask takes effect at the write edge
    check("R6 irqOut low with zero mask", DW'(irqOut), '0);
    @(negedge clk); sel = 1'b1; wrEn = 1'b1; addr = 0; wrData = 32'h0000_4000;
    @(negedge clk); sel = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R6 irqOut one edge after mask write", DW'(irqOut), 1);
    doRead(0, d); check("R6 mask readback", d, 32'h0000_4000);
    doWrite(0, 32'h0000_0001);
    check("R6 irqOut low after mask replace", DW'(irqOut), '0);

    // R10 unmapped and read-only writes
    doRead(6'd10, d); check("R10 unmapped offset reads zero", d, '0);
    check("R10 rdData zero without select", rdData, '0);
    doWrite(2, '1);
    doRead(2, d); check("R10 write to line offset ignored", d, '0);
    doRead(0, d); check("R10 mask unchanged by line-offset write", d, 32'h0000_0001);
    doRead(1, d); check("R10 pending unchanged by line-offset write", d, 32'h0000_C000);

    // R7 mid-run reset
    doReset();
    doRead(0, d); check("R7 mask cleared by reset", d, '0);
    doRead(1, d); check("R7 pending cleared by reset", d, '0);

    // R8 / R9 counters
    pulse(0, 3);
    doRead(6'd32, d); check("R8 counter0 after three pulses", d, 32'd3);
    @(negedge clk); irqIn[1] = 1'b1;
    waitCyc(20);
    doRead(6'd33, d); check("R8 held line counts once", d, 32'd1);
    irqIn[1] = 1'b0;
    pulse(5, 17);
    doRead(6'd37, d); check("R9 counter5 wraps after 17 pulses", d, 32'd1);
    doWrite(6'd37, '1);
    doRead(6'd37, d); check("R10 counter write ignored", d, 32'd1);
    doRead(6'd63, d); check("R8 untouched counter31 is zero", d, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule